// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches up to 54 general-purpose input pins and records chosen kinds of activity on each one. The pins are arranged as banks of 32. For every pin, software can enable six separate detectors: rising edge, falling edge, high level and low level, which all work on a resynchronized copy of the pin, plus an early rising edge and an early falling edge, which use a single capture stage and so report one cycle sooner. When an enabled detector fires, it sets a sticky bit in the bank's event status word.

Software clears a status bit by writing a one to it. Each bank drives its own interrupt line, which stays high while any status bit in that bank is set. Access is through a simple 32-bit register port. A write takes effect on the clock edge that samples it. Read data appears on the edge after the read request.

Register layout, in bytes: event status 0x40, rising enable 0x4C, falling enable 0x58, high-level enable 0x64, low-level enable 0x70, early rising enable 0x7C, early falling enable 0x88. Each register has one word per bank, with bank 1 at +4. Pin p maps to bank p/32, bit p%32.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every enable word and every status word reads 0 and both bank interrupt lines are low.
- R2: Enable words are read back through the register port at the offsets above. Bits for pins that do not exist (bank 1 bits 22..31) read as 0, so writing all ones to the bank 1 rising enable (0x50) reads back 0x003FFFFF.
- R3: With rising enable set, a 0-to-1 change on a pin sets its status bit on the third clock edge after the change, and the bank interrupt goes high with it.
- R4: With falling enable set, a 1-to-0 change sets the status bit. A 0-to-1 change does not set it unless rising is also enabled.
- R5: With both rising and falling enabled on a pin, either edge sets its status bit.
- R6: With high-level enable set, the status bit is set on every cycle that the pin is high, so a clear written while the pin stays high leaves the bit set.
- R7: With low-level enable set, the status bit is set while the pin is low.
- R8: The early rising and early falling detectors set the status bit on the second clock edge after the pin change, one cycle before the synchronized edge detectors would.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: Clearing an enable bit does not clear a status bit that is already set. Only a status write clears it.
- R11: Each bank interrupt is high exactly while that bank's status word is non-zero, independently of the other bank.
- R12: If a status clear and a new event for the same bit occur on the same clock edge, the bit ends up set.
- R13: Pin activity with no enable set leaves the status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 54 | Raw pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| bank_irq | output | 2 | One interrupt line per bank |

## Verification
Each result has a fixed latency, counted in clock edges from the point where the stimulus is driven:
- Synchronized edge and level events show up in status on the third edge after the pin changes.
- Early edge events show up on the second edge.
- A register write acts on the first edge.
- Read data is valid on the edge after the request.

The bench drives all inputs on falling edges. It samples the interrupt lines on a falling edge just before and just after the expected edge, so that a detection one cycle early or one cycle late fails. Read results are queued by the driver and compared a short delay after the capturing edge. The same-edge clear race is built by lining up a status write with the second edge after an early rising pin change.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int BANK_W         = 32;
    localparam int NUM_KINDS      = 7;
    localparam int REG_BASE       = 'h40;
    localparam int WORDS_PER_KIND = 3;

    typedef enum logic [2:0] {
        EK_STATUS = 3'd0,
        EK_RISE   = 3'd1,
        EK_FALL   = 3'd2,
        EK_HIGH   = 3'd3,
        EK_LOW    = 3'd4,
        EK_ARISE  = 3'd5,
        EK_AFALL  = 3'd6
    } evt_kind_e;

    typedef struct packed {
        logic      hit;
        evt_kind_e kind;
        logic [1:0] bank;
    } reg_sel_t;

    // three pipeline taps of one bank: first capture, synchronized, previous synchronized
    typedef struct packed {
        logic [BANK_W-1:0] stage1;
        logic [BANK_W-1:0] stage2;
        logic [BANK_W-1:0] stage3;
    } pin_view_t;

    function automatic reg_sel_t decode_addr(input logic [7:0] addr, input int nbanks);
        reg_sel_t r;
        int off;
        int wrd;
        int k;
        int b;
        r   = '{hit: 1'b0, kind: EK_STATUS, bank: 2'd0};
        off = int'(addr) - REG_BASE;
        if (off >= 0 && addr[1:0] == 2'b00) begin
            wrd = off / 4;
            k   = wrd / WORDS_PER_KIND;
            b   = wrd % WORDS_PER_KIND;
            if (k < NUM_KINDS && b < nbanks) begin
                r.hit  = 1'b1;
                r.kind = evt_kind_e'(k[2:0]);
                r.bank = b[1:0];
            end
        end
        return r;
    endfunction

    function automatic logic [BANK_W-1:0] low_mask(input int n);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] pin_raw,
    output pin_view_t         view
);
    logic [BANK_W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= pin_raw;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign view.stage1 = s1_q;
    assign view.stage2 = s2_q;
    assign view.stage3 = s3_q;
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int PINS_USED = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  pin_view_t                            view,
    input  logic [NUM_KINDS-1:0]                 wr_sel,
    input  logic [BANK_W-1:0]                    wdata,
    output logic [NUM_KINDS-1:0][BANK_W-1:0]     words,
    output logic [BANK_W-1:0]                    status,
    output logic                                 en_any
);
    localparam logic [BANK_W-1:0] PIN_MASK = low_mask(PINS_USED);

    logic [NUM_KINDS-1:1][BANK_W-1:0] en_q;
    logic [BANK_W-1:0]                status_q;
    logic [BANK_W-1:0]                evt;
    logic [BANK_W-1:0]                clr;
    logic [BANK_W-1:0]                lvl, prv, cap, cap_prv;

    assign cap     = view.stage1;
    assign cap_prv = view.stage2;
    assign lvl     = view.stage2;
    assign prv     = view.stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            for (int k = 1; k < NUM_KINDS; k++) begin
                if (wr_sel[k]) en_q[k] <= wdata & PIN_MASK;
            end
        end
    end

    always_comb begin
        evt = (en_q[EK_RISE]  &  lvl    & ~prv)
            | (en_q[EK_FALL]  & ~lvl    &  prv)
            | (en_q[EK_HIGH]  &  lvl)
            | (en_q[EK_LOW]   & ~lvl)
            | (en_q[EK_ARISE] &  cap    & ~cap_prv)
            | (en_q[EK_AFALL] & ~cap    &  cap_prv);
        clr = wr_sel[EK_STATUS] ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= ((status_q & ~clr) | evt) & PIN_MASK;
    end

    always_comb begin
        words[EK_STATUS] = status_q;
        for (int k = 1; k < NUM_KINDS; k++) words[k] = en_q[k];
    end

    assign status = status_q;
    assign en_any = |en_q;
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [(NUM_PINS+31)/32-1:0] bank_irq
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int PAD_W     = NUM_BANKS * BANK_W;

    logic [PAD_W-1:0]                                   pin_pad;
    reg_sel_t                                           sel;
    logic [NUM_BANKS-1:0]                               bank_en_any;
    logic [NUM_BANKS-1:0][BANK_W-1:0]                   bank_status;
    logic [NUM_BANKS-1:0][NUM_KINDS-1:0][BANK_W-1:0]    bank_words;
    logic [BANK_W-1:0]                                  rd_word;

    assign pin_pad = PAD_W'(pin_in);
    assign sel     = decode_addr(reg_addr, NUM_BANKS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int USED = (NUM_PINS - b * BANK_W) < BANK_W ? (NUM_PINS - b * BANK_W) : BANK_W;
        pin_view_t            view;
        logic [NUM_KINDS-1:0] wr_sel;

        assign wr_sel = (reg_wr && sel.hit && sel.bank == 2'(b))
                      ? (NUM_KINDS'(1) << sel.kind) : '0;

        gpio_evt_sync sync_i (
            .clk     (clk),
            .rst     (rst),
            .pin_raw (pin_pad[b*BANK_W +: BANK_W]),
            .view    (view)
        );

        gpio_evt_bank #(.PINS_USED(USED)) bank_i (
            .clk    (clk),
            .rst    (rst),
            .view   (view),
            .wr_sel (wr_sel),
            .wdata  (reg_wdata),
            .words  (bank_words[b]),
            .status (bank_status[b]),
            .en_any (bank_en_any[b])
        );

        assign bank_irq[b] = |bank_status[b];
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.hit && sel.bank == 2'(b)) rd_word = bank_words[b][sel.kind];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_BANKS-1:0] bank_irq,
    input logic                 reg_wr,
    input logic [7:0]           reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [NUM_BANKS-1:0] bank_en_any
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        localparam logic [7:0] ST_ADDR = 8'(8'h40 + 4 * b);

        AST_RESET_QUIET: assert property (@(posedge clk)
            rst |=> !bank_irq[b]);                                            // R1

        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_irq[b]) |-> $past(bank_en_any[b]));                    // R13

        AST_FULL_CLEAR_DRAINS: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == ST_ADDR && reg_wdata == 32'hFFFF_FFFF && !bank_en_any[b])
            |=> !bank_irq[b]);                                                // R9

        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (bank_irq[b] && !(reg_wr && reg_addr == ST_ADDR)) |=> bank_irq[b]); // R10
    end
endmodule

bind gpio_evt_unit gpio_evt_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bank_irq    (bank_irq),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .bank_en_any (bank_en_any)
);

// File: tb/gpio_evt_unit_tb_top.sv
module gpio_evt_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [53:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  bank_irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    gpio_evt_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pins),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bank_irq  (bank_irq)
    );

    localparam int K_ST = 0, K_RI = 1, K_FA = 2, K_HI = 3, K_LO = 4, K_AR = 5, K_AF = 6;

    function automatic logic [7:0] ra(input int kind, input int bank);
        return 8'(8'h40 + kind * 12 + bank * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: read data is due on the edge that samples reg_rd
    always @(posedge clk) begin
        logic rd_now;
        logic [31:0] e;
        string t;
        rd_now = reg_rd;
        #2;
        if (rd_now) begin
            if (exp_q.size() == 0) begin
                chk("unexpected read", reg_rdata, 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, reg_rdata, e);
            end
        end
    end

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 irq after reset", 32'(bank_irq), 32'h0);
        bus_rd(ra(K_ST, 0), 32'h0, "R1 status bank0");
        bus_rd(ra(K_ST, 1), 32'h0, "R1 status bank1");
        bus_rd(ra(K_HI, 0), 32'h0, "R1 high enable bank0");
        bus_rd(ra(K_AF, 1), 32'h0, "R1 async fall enable bank1");

        // R2 readback and unimplemented bits
        bus_wr(ra(K_RI, 1), 32'hFFFF_FFFF);
        bus_rd(ra(K_RI, 1), 32'h003F_FFFF, "R2 bank1 rise mask");
        bus_wr(ra(K_FA, 0), 32'hA5A5_0000);
        bus_rd(ra(K_FA, 0), 32'hA5A5_0000, "R2 bank0 fall readback");
        bus_wr(ra(K_RI, 1), 32'h0);
        bus_wr(ra(K_FA, 0), 32'h0);
        bus_rd(ra(K_FA, 0), 32'h0, "R2 fall cleared");

        // R13 activity with nothing enabled
        pins[5] = 1'b1; idle(4); pins[5] = 1'b0; pins[45] = 1'b1; idle(4); pins[45] = 1'b0; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0, "R13 status bank0");
        bus_rd(ra(K_ST, 1), 32'h0, "R13 status bank1");

        // R3 rising edge with exact latency
        bus_wr(ra(K_RI, 0), 32'h0000_0008);
        pins[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3 irq not yet after 2 edges", 32'(bank_irq[0]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 irq after 3 edges", 32'(bank_irq[0]), 32'h1);
        chk("R11 other bank quiet", 32'(bank_irq[1]), 32'h0);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R3 status bit3");
        pins[3] = 1'b0; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R4 fall ignored by rise-only");
        // R9 write-one-to-clear
        bus_wr(ra(K_ST, 0), 32'h0);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R9 zero write keeps");
        bus_wr(ra(K_ST, 0), 32'h0000_0008);
        bus_rd(ra(K_ST, 0), 32'h0, "R9 one write clears");
        chk("R11 irq low when status empty", 32'(bank_irq), 32'h0);

        // R4 falling only
        bus_wr(ra(K_RI, 0), 32'h0);
        bus_wr(ra(K_FA, 0), 32'h0000_0008);
        pins[3] = 1'b1; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0, "R4 rise ignored by fall-only");
        pins[3] = 1'b0; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R4 fall sets");
        bus_wr(ra(K_ST, 0), 32'h0000_0008);

        // R5 both edges
        bus_wr(ra(K_RI, 0), 32'h0000_0008);
        pins[3] = 1'b1; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R5 rising half");
        bus_wr(ra(K_ST, 0), 32'h0000_0008);
        bus_rd(ra(K_ST, 0), 32'h0, "R5 cleared");
        pins[3] = 1'b0; idle(4);
        bus_rd(ra(K_ST, 0), 32'h0000_0008, "R5 falling half");
        bus_wr(ra(K_RI, 0), 32'h0);
        bus_wr(ra(K_FA, 0), 32'h0);
        bus_wr(ra(K_ST, 0), 32'h0000_0008);

        // R6 high level on pin 40 (bank1 bit8)
        bus_wr(ra(K_HI, 1), 32'h0000_0100);
        pins[40] = 1'b1; idle(5);
        bus_rd(ra(K_ST, 1), 32'h0000_0100, "R6 high sets");
        chk("R11 bank1 irq", 32'(bank_irq), 32'h2);
        bus_wr(ra(K_ST, 1), 32'h0000_0100);
        bus_rd(ra(K_ST, 1), 32'h0000_0100, "R6 clear while high re-latches");
        // R10 disabling keeps status
        bus_wr(ra(K_HI, 1), 32'h0);
        pins[40] = 1'b0; idle(4);
        bus_rd(ra(K_ST, 1), 32'h0000_0100, "R10 status survives disable");
        bus_wr(ra(K_ST, 1), 32'h0000_0100);
        bus_rd(ra(K_ST, 1), 32'h0, "R10 explicit clear");

        // R7 low level on pin 0
        bus_wr(ra(K_LO, 0), 32'h0000_0001);
        idle(4);
        bus_rd(ra(K_ST, 0), 32'h0000_0001, "R7 low sets");
        pins[0] = 1'b1; idle(4);
        bus_wr(ra(K_ST, 0), 32'h0000_0001);
        bus_rd(ra(K_ST, 0), 32'h0, "R7 clear once high");
        bus_wr(ra(K_LO, 0), 32'h0);
        pins[0] = 1'b0; idle(4);

        // R8 early rising on pin 7: two edges
        bus_wr(ra(K_AR, 0), 32'h0000_0080);
        pins[7] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 early rise not after 1 edge", 32'(bank_irq[0]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 early rise after 2 edges", 32'(bank_irq[0]), 32'h1);
        bus_wr(ra(K_AR, 0), 32'h0);
        bus_wr(ra(K_ST, 0), 32'h0000_0080);
        bus_wr(ra(K_AF, 0), 32'h0000_0080);
        pins[7] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 early fall not after 1 edge", 32'(bank_irq[0]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 early fall after 2 edges", 32'(bank_irq[0]), 32'h1);
        bus_rd(ra(K_ST, 0), 32'h0000_0080, "R8 status bit7");
        bus_wr(ra(K_AF, 0), 32'h0);
        bus_wr(ra(K_ST, 0), 32'h0000_0080);

        // R12 clear and new event on the same edge
        bus_wr(ra(K_AR, 0), 32'h0000_0200);
        pins[9] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ra(K_ST, 0); reg_wdata = 32'h0000_0200;
        @(negedge clk);
        reg_wr = 1'b0;
        bus_rd(ra(K_ST, 0), 32'h0000_0200, "R12 event wins over clear");
        bus_wr(ra(K_ST, 0), 32'h0000_0200);
        bus_rd(ra(K_ST, 0), 32'h0, "R12 later clear works");
        bus_wr(ra(K_AR, 0), 32'h0);

        idle(4);
        if (exp_q.size() != 0) chk("pending reads drained", 32'(exp_q.size()), 32'h0);
        summary();
        $finish;
    end
endmodule